// File: doc/BRIEF.md
# Acknowledge-Polling EEPROM Write Sequencer

This block sits on the master side of an I2C bus. It writes one byte into a serial EEPROM and then waits for the device's internal write cycle to finish. It does not wait a fixed worst-case time. Instead it polls: it repeats a start condition and a write-direction control byte until the device acknowledges. The bus is therefore free again as soon as the memory is ready.

The block does not drive SCL or SDA. It sends byte-level commands (start, stop, send byte) to a bit-level engine over a request/done handshake. The engine reports with each completed byte whether it was acknowledged.

A user pulses `go` while the block is idle, with the device address, word address, data byte and a poll limit. The block then reports exactly one of three outcomes with a single-cycle pulse:
- `done`: the device acknowledged a poll, so the next operation may proceed.
- `err_nack`: a byte of the write command was not acknowledged.
- `err_timeout`: the poll limit was used up.

Top module: `ackpoll_write_seq`

## Requirements
- R1: While and after reset, with no `go`, `busy`, `done`, `err_nack`, `err_timeout` and `cmd_req` are all low.
- R2: A `go` seen while idle captures `dev_addr`, `word_addr`, `wr_data` and `max_polls`, sets `busy`, and issues START, SEND `{dev_addr,0}`, SEND word address, SEND data, STOP, in that order. Command codes on `cmd_op` are 01 start, 10 stop and 11 send. `cmd_data` carries the byte for a send and is zero otherwise.
- R3: If any of the three write bytes is not acknowledged (`eng_ack`=0 with `eng_done`), the block issues STOP, then pulses `err_nack`, and performs no polling.
- R4: The write STOP is followed at once by the first poll's START, with no delay beyond the one-cycle handshake gap.
- R5: Each poll is a START followed by SEND `{dev_addr,0}` (bit 0, the R/W bit, is zero).
- R6: A poll that is not acknowledged is followed by STOP and then a new poll, unless the limit is reached.
- R7: An acknowledged poll is followed by STOP, then `done` pulses.
- R8: After `max_polls` unacknowledged polls, the block issues STOP and then pulses `err_timeout`. A `max_polls` of 0 acts as 1.
- R9: The outcome pulse is high for exactly one cycle. It comes in the cycle after the final STOP's `eng_done` is sampled, and `busy` falls in that same cycle.
- R10: A `go` while `busy` is ignored. The running sequence keeps its captured values, and no second sequence starts.
- R11: `cmd_req` stays high with stable `cmd_op`/`cmd_data` until `eng_done`. It is low in the cycle after `eng_done`, and only then is the next command raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start strobe, accepted when idle |
| dev_addr | input | BYTE_W-1 | 7-bit device address |
| word_addr | input | BYTE_W | Memory word address |
| wr_data | input | BYTE_W | Byte to store |
| max_polls | input | POLL_W | Maximum number of polls (0 treated as 1) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: device acknowledged a poll |
| err_nack | output | 1 | One-cycle pulse: write byte not acknowledged |
| err_timeout | output | 1 | One-cycle pulse: poll limit used up |
| cmd_req | output | 1 | Command request to the byte engine |
| cmd_op | output | 2 | Command code: 01 start, 10 stop, 11 send |
| cmd_data | output | BYTE_W | Byte to send (zero for start and stop) |
| eng_done | input | 1 | Engine finished the current command (one cycle) |
| eng_ack | input | 1 | Acknowledge bit for a completed send |

## Verification
The outcome pulse is due exactly one clock after the engine model's final `eng_done`. The bench stamps the cycle of each `eng_done` and checks that the pulse appears in the following cycle. It then checks that the pulse is gone one cycle later.

Commands are logged when the engine model accepts them. A request raised again before the one-cycle gap would be logged twice, so the gap is checked too. The log is compared with a sequence computed from the acknowledge script, the captured operands and the poll limit.

All sampling happens on the falling edge, half a cycle clear of every register update.

// File: rtl/ackpoll_pkg.sv
// Shared types for the acknowledge-polling write sequencer.
// Assumes an 8-bit byte bus where the control byte is {address, R/W}.
package ackpoll_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_START = 2'b01,
        OP_STOP  = 2'b10,
        OP_SEND  = 2'b11
    } bus_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_W_START,
        ST_W_DEV,
        ST_W_WORD,
        ST_W_DATA,
        ST_W_STOP,
        ST_P_START,
        ST_P_DEV,
        ST_P_STOP,
        ST_F_STOP
    } seq_st_e;

    typedef enum logic [1:0] {
        RES_OK,
        RES_NACK,
        RES_TMO
    } res_e;
endpackage

// File: rtl/ackpoll_cmd_drv.sv
// Command driver: turns the controller's wanted command into a
// request/done handshake toward the byte engine.
// Assumes the engine pulses eng_done for one cycle per request.
// The request drops for one cycle after each done, so every
// command is a fresh request.
module ackpoll_cmd_drv
    import ackpoll_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              want_valid,
    input  bus_op_e           want_op,
    input  logic [BYTE_W-1:0] want_data,
    input  logic              eng_done,
    output logic              cmd_req,
    output bus_op_e           cmd_op,
    output logic [BYTE_W-1:0] cmd_data
);
    // Raise a request, hold it until done, then drop it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_req  <= 1'b0;
            cmd_op   <= OP_NONE;
            cmd_data <= '0;
        end else if (cmd_req && eng_done) begin
            cmd_req  <= 1'b0;
        end else if (!cmd_req && want_valid) begin
            cmd_req  <= 1'b1;
            cmd_op   <= want_op;
            cmd_data <= want_data;
        end
    end

    // R11
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && !eng_done) |=> (cmd_req && $stable(cmd_op) && $stable(cmd_data)));
    // R11
    cmd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req && eng_done) |=> !cmd_req);
endmodule

// File: rtl/ackpoll_poll_ctr.sv
// Poll counter: holds the poll limit captured at start and counts
// unacknowledged polls. It flags when the poll in flight is the last
// one allowed. Assumes a limit of zero means one poll.
module ackpoll_poll_ctr #(
    parameter int POLL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic [POLL_W-1:0] limit_in,
    input  logic              inc,
    output logic              last_poll
);
    localparam int CW = POLL_W + 1;

    logic [POLL_W-1:0] lim_q;
    logic [POLL_W-1:0] cnt_q;

    // Capture the limit on start and count missed polls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q <= POLL_W'(1);
            cnt_q <= '0;
        end else if (clear) begin
            lim_q <= (limit_in == '0) ? POLL_W'(1) : limit_in;
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + POLL_W'(1);
        end
    end

    // The current poll is the last one if one more miss reaches the limit.
    always_comb begin
        last_poll = ({1'b0, cnt_q} + CW'(1)) == {1'b0, lim_q};
    end

    // R8
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim_q);
    // R8
    poll_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && last_poll && !clear) |=> (cnt_q == lim_q));
endmodule

// File: rtl/ackpoll_ctrl.sv
// Sequence controller: walks through the write command, the stop
// that starts the device's write cycle, and then the poll loop.
// Each command state leaves on the engine's done. The outcome pulses
// are registered and fire as the controller returns to idle.
module ackpoll_ctrl
    import ackpoll_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int POLL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [BYTE_W-2:0] dev_addr,
    input  logic [BYTE_W-1:0] word_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              eng_done,
    input  logic              eng_ack,
    input  logic              last_poll,
    output logic              busy,
    output logic              done,
    output logic              err_nack,
    output logic              err_timeout,
    output logic              accept,
    output logic              poll_miss,
    output logic              want_valid,
    output bus_op_e           want_op,
    output logic [BYTE_W-1:0] want_data
);
    seq_st_e           state_q, state_n;
    res_e              res_q, res_n;
    logic [BYTE_W-2:0] dev_q;
    logic [BYTE_W-1:0] word_q;
    logic [BYTE_W-1:0] data_q;
    logic              fin;

    // Next-state and outcome selection.
    always_comb begin
        state_n   = state_q;
        res_n     = res_q;
        poll_miss = 1'b0;
        fin       = 1'b0;
        accept    = 1'b0;
        case (state_q)
            ST_IDLE: if (go) begin
                accept  = 1'b1;
                state_n = ST_W_START;
            end
            ST_W_START: if (eng_done) state_n = ST_W_DEV;
            ST_W_DEV, ST_W_WORD, ST_W_DATA: if (eng_done) begin
                if (!eng_ack) begin
                    res_n   = RES_NACK;
                    state_n = ST_F_STOP;
                end else if (state_q == ST_W_DEV) begin
                    state_n = ST_W_WORD;
                end else if (state_q == ST_W_WORD) begin
                    state_n = ST_W_DATA;
                end else begin
                    state_n = ST_W_STOP;
                end
            end
            ST_W_STOP:  if (eng_done) state_n = ST_P_START;
            ST_P_START: if (eng_done) state_n = ST_P_DEV;
            ST_P_DEV: if (eng_done) begin
                if (eng_ack) begin
                    res_n   = RES_OK;
                    state_n = ST_F_STOP;
                end else begin
                    poll_miss = 1'b1;
                    if (last_poll) begin
                        res_n   = RES_TMO;
                        state_n = ST_F_STOP;
                    end else begin
                        state_n = ST_P_STOP;
                    end
                end
            end
            ST_P_STOP: if (eng_done) state_n = ST_P_START;
            ST_F_STOP: if (eng_done) begin
                fin     = 1'b1;
                state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State, captured operands and registered outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            res_q       <= RES_OK;
            dev_q       <= '0;
            word_q      <= '0;
            data_q      <= '0;
            done        <= 1'b0;
            err_nack    <= 1'b0;
            err_timeout <= 1'b0;
        end else begin
            state_q     <= state_n;
            res_q       <= res_n;
            done        <= fin && (res_q == RES_OK);
            err_nack    <= fin && (res_q == RES_NACK);
            err_timeout <= fin && (res_q == RES_TMO);
            if (accept) begin
                dev_q  <= dev_addr;
                word_q <= word_addr;
                data_q <= wr_data;
            end
        end
    end

    // Map the state to the command the engine should carry out.
    always_comb begin
        busy       = (state_q != ST_IDLE);
        want_valid = busy;
        want_data  = '0;
        case (state_q)
            ST_W_START, ST_P_START:       want_op = OP_START;
            ST_W_STOP, ST_P_STOP, ST_F_STOP: want_op = OP_STOP;
            ST_W_DEV, ST_P_DEV: begin
                want_op   = OP_SEND;
                want_data = {dev_q, 1'b0};
            end
            ST_W_WORD: begin
                want_op   = OP_SEND;
                want_data = word_q;
            end
            ST_W_DATA: begin
                want_op   = OP_SEND;
                want_data = data_q;
            end
            default: want_op = OP_NONE;
        endcase
    end

    // R9
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err_nack, err_timeout}));
    // R9
    result_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err_nack || err_timeout) |-> (!busy && $past(busy)));
    // R10
    start_by_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(go));
    // R10
    operands_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(dev_q) && $stable(word_q) && $stable(data_q)));
endmodule

// File: rtl/ackpoll_write_seq.sv
// Top level of the acknowledge-polling write sequencer.
// Connects the controller, the poll counter and the command driver.
// Assumes a byte engine that answers every request with one eng_done
// pulse, with eng_ack valid in that cycle.
module ackpoll_write_seq
    import ackpoll_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int POLL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [BYTE_W-2:0] dev_addr,
    input  logic [BYTE_W-1:0] word_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [POLL_W-1:0] max_polls,
    output logic              busy,
    output logic              done,
    output logic              err_nack,
    output logic              err_timeout,
    output logic              cmd_req,
    output logic [1:0]        cmd_op,
    output logic [BYTE_W-1:0] cmd_data,
    input  logic              eng_done,
    input  logic              eng_ack
);
    logic              accept;
    logic              poll_miss;
    logic              last_poll;
    logic              want_valid;
    bus_op_e           want_op;
    logic [BYTE_W-1:0] want_data;
    bus_op_e           op_q;

    ackpoll_ctrl #(.BYTE_W(BYTE_W), .POLL_W(POLL_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .go(go),
        .dev_addr(dev_addr), .word_addr(word_addr), .wr_data(wr_data),
        .eng_done(eng_done), .eng_ack(eng_ack), .last_poll(last_poll),
        .busy(busy), .done(done), .err_nack(err_nack), .err_timeout(err_timeout),
        .accept(accept), .poll_miss(poll_miss),
        .want_valid(want_valid), .want_op(want_op), .want_data(want_data)
    );

    ackpoll_poll_ctr #(.POLL_W(POLL_W)) ctr_i (
        .clk(clk), .rst_n(rst_n), .clear(accept), .limit_in(max_polls),
        .inc(poll_miss), .last_poll(last_poll)
    );

    ackpoll_cmd_drv #(.BYTE_W(BYTE_W)) drv_i (
        .clk(clk), .rst_n(rst_n), .want_valid(want_valid), .want_op(want_op),
        .want_data(want_data), .eng_done(eng_done),
        .cmd_req(cmd_req), .cmd_op(op_q), .cmd_data(cmd_data)
    );

    // Present the command code as plain bits at the boundary.
    always_comb begin
        cmd_op = op_q;
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_req);
endmodule

// File: tb/ackpoll_write_seq_tb.sv
// Bench for the acknowledge-polling write sequencer.
// Contains a byte-engine model driven by an acknowledge script, and
// a reference sequence computed from the requirements.
module ackpoll_write_seq_tb_top;
    localparam int BYTE_W = 8;
    localparam int POLL_W = 8;
    localparam int LOGN   = 128;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              go = 1'b0;
    logic [BYTE_W-2:0] dev_addr = '0;
    logic [BYTE_W-1:0] word_addr = '0;
    logic [BYTE_W-1:0] wr_data = '0;
    logic [POLL_W-1:0] max_polls = '0;
    logic              busy, done, err_nack, err_timeout, cmd_req;
    logic [1:0]        cmd_op;
    logic [BYTE_W-1:0] cmd_data;
    logic              eng_done = 1'b0;
    logic              eng_ack = 1'b0;

    ackpoll_write_seq #(.BYTE_W(BYTE_W), .POLL_W(POLL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .go(go), .dev_addr(dev_addr),
        .word_addr(word_addr), .wr_data(wr_data), .max_polls(max_polls),
        .busy(busy), .done(done), .err_nack(err_nack), .err_timeout(err_timeout),
        .cmd_req(cmd_req), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .eng_done(eng_done), .eng_ack(eng_ack)
    );

    always #4 clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;

    // Acknowledge script and logs shared with the engine model.
    int          nack_at_s = 3;
    int          busy_polls_s = 0;
    int          send_cnt = 0;
    int          log_n = 0;
    logic [9:0]  log_q [LOGN];
    int          exp_n = 0;
    logic [9:0]  exp_q [LOGN];
    int unsigned last_done_cyc = 0;
    bit          gap_bad = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Engine model: accepts a request, waits 1..3 cycles, answers with ack.
    initial begin
        forever begin
            @(negedge clk);
            if (cmd_req) begin
                logic ack;
                if (log_n < LOGN) log_q[log_n] = {cmd_op, (cmd_op == 2'b11) ? cmd_data : 8'h00};
                log_n++;
                ack = 1'b1;
                if (cmd_op == 2'b11) begin
                    if (send_cnt < 3) ack = (send_cnt != nack_at_s);
                    else ack = ((send_cnt - 3) >= busy_polls_s);
                    send_cnt++;
                end
                repeat ($urandom_range(1, 3) - 1) @(negedge clk);
                eng_done = 1'b1;
                eng_ack  = ack;
                last_done_cyc = cyc;
                @(negedge clk);
                eng_done = 1'b0;
                eng_ack  = 1'b0;
                // R11: request must be down the cycle after done
                if (cmd_req) gap_bad = 1;
            end
        end
    end

    function automatic void push(input logic [1:0] op, input logic [7:0] d);
        if (exp_n < LOGN) exp_q[exp_n] = {op, d};
        exp_n++;
    endfunction

    // Reference sequence; returns 0 ok, 1 nack, 2 timeout.
    function automatic int build_exp(input logic [6:0] dv, input logic [7:0] wa,
                                     input logic [7:0] wd, input int lim,
                                     input int nack_at, input int bp);
        int eff;
        eff = (lim == 0) ? 1 : lim;
        exp_n = 0;
        push(2'b01, 8'h00);
        push(2'b11, {dv, 1'b0});
        if (nack_at == 0) begin push(2'b10, 8'h00); return 1; end
        push(2'b11, wa);
        if (nack_at == 1) begin push(2'b10, 8'h00); return 1; end
        push(2'b11, wd);
        if (nack_at == 2) begin push(2'b10, 8'h00); return 1; end
        push(2'b10, 8'h00);
        for (int i = 0; i < 256; i++) begin
            push(2'b01, 8'h00);
            push(2'b11, {dv, 1'b0});
            push(2'b10, 8'h00);
            if (i >= bp) return 0;
            if (i + 1 == eff) return 2;
        end
        return 2;
    endfunction

    task automatic run_case(input logic [6:0] dv, input logic [7:0] wa, input logic [7:0] wd,
                            input int lim, input int nack_at, input int bp, input bit poke);
        int exp_res, got_res, wait_n, mism;
        exp_res = build_exp(dv, wa, wd, lim, nack_at, bp);
        nack_at_s = nack_at; busy_polls_s = bp; send_cnt = 0; log_n = 0; gap_bad = 0;
        @(negedge clk);
        dev_addr = dv; word_addr = wa; wr_data = wd; max_polls = POLL_W'(lim); go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        dev_addr = ~dv; word_addr = ~wa; wr_data = ~wd; max_polls = 8'd200;
        check(busy === 1'b1, "R2 busy after go", busy, 1);
        wait_n = 0;
        got_res = -1;
        while (got_res < 0 && wait_n < 5000) begin
            @(negedge clk);
            wait_n++;
            // R10: a go while busy must be ignored
            if (poke && wait_n == 4) go = 1'b1;
            else go = 1'b0;
            if (done) got_res = 0;
            else if (err_nack) got_res = 1;
            else if (err_timeout) got_res = 2;
        end
        go = 1'b0;
        if (got_res < 0) begin
            check(1'b0, "watchdog", wait_n, 5000);
            return;
        end
        case (exp_res)
            0: check(got_res == 0, "R7 done outcome", got_res, exp_res);
            1: check(got_res == 1, "R3 nack outcome", got_res, exp_res);
            default: check(got_res == 2, "R8 timeout outcome", got_res, exp_res);
        endcase
        check(cyc == last_done_cyc + 1, "R9 outcome timing", int'(cyc), int'(last_done_cyc + 1));
        check(busy === 1'b0, "R9 busy falls with outcome", busy, 0);
        mism = -1;
        for (int i = 0; i < exp_n && i < LOGN; i++)
            if (mism < 0 && (i >= log_n || log_q[i] !== exp_q[i])) mism = i;
        check(log_n == exp_n && mism < 0, "R2 R4 R5 R6 command sequence",
              (mism < 0) ? log_n : int'(log_q[mism]), (mism < 0) ? exp_n : int'(exp_q[mism]));
        check(!gap_bad, "R11 request gap after done", gap_bad, 0);
        @(negedge clk);
        check({done, err_nack, err_timeout} == 3'b000, "R9 single-cycle pulse",
              {done, err_nack, err_timeout}, 0);
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && cmd_req === 1'b0, "R10 no second sequence", busy, 0);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h1D2E3F);
        repeat (3) @(negedge clk);
        // R1: reset state
        check({busy, done, err_nack, err_timeout, cmd_req} == 5'b0, "R1 state in reset",
              {busy, done, err_nack, err_timeout, cmd_req}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check({busy, done, err_nack, err_timeout, cmd_req} == 5'b0, "R1 idle after reset",
              {busy, done, err_nack, err_timeout, cmd_req}, 0);

        run_case(7'h50, 8'h12, 8'hA5, 4, 3, 0, 0);   // R7 immediate ack
        run_case(7'h51, 8'h00, 8'hFF, 8, 3, 3, 0);   // R6 three busy polls
        run_case(7'h2A, 8'h7F, 8'h3C, 5, 3, 4, 0);   // R7 ack on last allowed poll
        run_case(7'h2A, 8'h80, 8'hC3, 5, 3, 5, 0);   // R8 limit reached exactly
        run_case(7'h7F, 8'h01, 8'h02, 0, 3, 2, 0);   // R8 zero limit acts as one
        run_case(7'h10, 8'h20, 8'h30, 4, 0, 0, 0);   // R3 control byte nack
        run_case(7'h11, 8'h21, 8'h31, 4, 1, 0, 0);   // R3 word address nack
        run_case(7'h12, 8'h22, 8'h32, 4, 2, 0, 0);   // R3 data nack
        run_case(7'h33, 8'h44, 8'h55, 6, 3, 2, 1);   // R10 go during busy

        for (int k = 0; k < 24; k++) begin
            logic [6:0] dv;
            logic [7:0] wa, wd;
            int lim, na, bp;
            dv  = 7'($urandom);
            wa  = 8'($urandom);
            wd  = 8'($urandom);
            lim = $urandom_range(0, 12);
            na  = ($urandom_range(0, 5) == 0) ? $urandom_range(0, 2) : 3;
            bp  = $urandom_range(0, 13);
            run_case(dv, wa, wd, lim, na, bp, k[0]);
        end

        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule